// File: doc/BRIEF.md
# Three-Input Divided Clock Selector

This block is one slice of a clock generator that serves several outputs. Each output takes one of three reference inputs and divides it by a ratio that software sets. Every output keeps a separate ratio for each of the three inputs, so a switch of input also brings in the ratio held for that input. A 2-bit select field per output picks input 0, 1 or 2. The fourth code switches the output off. The references arrive as single-cycle enable pulses on one system clock. Each output is likewise a single-cycle tick that marks one period of the divided clock.

Software works through a small word-addressed register file. The select fields of all outputs are packed into two registers. The divider ratios are spread over three per-input banks. Three status registers, one per input, report whether each output is running on that input. After it writes a new select code, software polls the running bit of the chosen input. It treats a bit that stays low past its time limit as a failed switch.

Top module: `clkmux3_slice`

## Requirements
- R1: After reset every select field reads 3 (off), every divider field reads 0, every status register reads 0 and no output ticks.
- R2: The select field of output o sits at bit position p = SEL_LSB + 2*o of the low select register (SEL_LO_ADDR). When p is 32 or more, the field sits in the high select register (SEL_HI_ADDR) at position p - 32. Bits that belong to no field read 0.
- R3: The divider ratio of output o for input i is bits [4:0] of the word at DIV_BASEi + 4*o. Bits [31:5] of that word read 0.
- R4: With ratio N on the selected input, output ticks repeat every N+1 enable pulses of that input (ratios 1 to 32).
- R5: Select codes 0, 1 and 2 route reference enable bit 0, 1 and 2 to the output's divider.
- R6: Select code 3 stops the output's ticks from the next cycle on. It also clears the output's running bit in all three status registers.
- R7: Bit STAT_LSB + o of the status register at STAT_BASE + 4*i is 1 only while output o selects input i and is running. It reads 0 in the other two status registers.
- R8: After a select change the running bit stays 0 until the new selection has produced two output ticks, and then reads 1. It drops to 0 in the cycle after a select write that changes the code.
- R9: Writing the ratio of an input that an output does not select leaves that output's tick period unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 3 | One enable pulse per input-clock period, one bit per reference |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| out_tick | output | NUM_OUT | One-cycle tick per divided output period |

## Verification
The bench uses four outputs with SEL_LSB = 28 and STAT_LSB = 4. Outputs 0 and 1 then occupy the top four bits of the low select register, and outputs 2 and 3 spill into bits 3:0 of the high one, so both packing paths and the split are covered. The references pulse every cycle, every second cycle and every third cycle. Each input therefore gives its own tick period, and a wrong routing shows up as a wrong period. The ratios run from 0 to 31, which covers the ends of the 5-bit field, and the offset status bits check that the placement of the running flag is right.

// File: rtl/clkmux3_pkg.sv
package clkmux3_pkg;
    localparam int NUM_IN   = 3;
    localparam int SEL_W    = 2;
    localparam int DIV_W    = 5;
    localparam int SEEN_MAX = 2;

    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [DIV_W-1:0] ratio_t;

    localparam sel_t SEL_OFF = sel_t'(3);

    typedef struct packed {
        sel_t        sel;
        ratio_t      cnt;
        logic [1:0]  seen;
        logic        tick;
    } chan_state_t;
endpackage

// File: rtl/clkmux3_regs.sv
module clkmux3_regs
    import clkmux3_pkg::*;
#(
    parameter int               NUM_OUT     = 4,
    parameter int               ADDR_W      = 12,
    parameter int               SEL_LSB     = 28,
    parameter int               STAT_LSB    = 4,
    parameter logic [ADDR_W-1:0] SEL_LO_ADDR = 12'h010,
    parameter logic [ADDR_W-1:0] SEL_HI_ADDR = 12'h014,
    parameter logic [ADDR_W-1:0] STAT_BASE   = 12'h020,
    parameter logic [ADDR_W-1:0] DIV_BASE0   = 12'h100,
    parameter logic [ADDR_W-1:0] DIV_BASE1   = 12'h200,
    parameter logic [ADDR_W-1:0] DIV_BASE2   = 12'h300
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    we,
    input  logic [ADDR_W-1:0]                       addr,
    input  logic [31:0]                             wdata,
    output logic [31:0]                             rdata,
    input  logic [NUM_OUT-1:0]                      run,
    output logic [NUM_OUT-1:0][SEL_W-1:0]           sel_o,
    output logic [NUM_IN-1:0][NUM_OUT-1:0][DIV_W-1:0] div_o
);
    localparam logic [ADDR_W-1:0] DIV_BASE [NUM_IN] = '{DIV_BASE0, DIV_BASE1, DIV_BASE2};

    typedef struct packed {
        logic [NUM_OUT-1:0][SEL_W-1:0]             sel;
        logic [NUM_IN-1:0][NUM_OUT-1:0][DIV_W-1:0] div;
    } regs_t;

    regs_t       st_d, st_q;
    logic [31:0] rdata_c;

    always_comb begin
        st_d    = st_q;
        rdata_c = '0;
        for (int o = 0; o < NUM_OUT; o++) begin
            int pos;
            int bitp;
            logic [ADDR_W-1:0] sel_addr;
            pos      = SEL_LSB + SEL_W * o;
            bitp     = pos % 32;
            sel_addr = (pos >= 32) ? SEL_HI_ADDR : SEL_LO_ADDR;
            if (we && addr == sel_addr) begin
                st_d.sel[o] = wdata[bitp +: SEL_W];
            end
            if (addr == sel_addr) begin
                rdata_c[bitp +: SEL_W] = st_q.sel[o];
            end
            for (int i = 0; i < NUM_IN; i++) begin
                if (addr == DIV_BASE[i] + ADDR_W'(4 * o)) begin
                    if (we) begin
                        st_d.div[i][o] = wdata[DIV_W-1:0];
                    end
                    rdata_c[DIV_W-1:0] = st_q.div[i][o];
                end
                if (addr == STAT_BASE + ADDR_W'(4 * i)) begin
                    rdata_c[STAT_LSB + o] = run[o] && (st_q.sel[o] == sel_t'(i));
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sel <= '1;
            st_q.div <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = rdata_c;
    assign sel_o = st_q.sel;
    assign div_o = st_q.div;

    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_chk_in
        for (genvar go = 0; go < NUM_OUT; go++) begin : g_chk_out
            // R3: a ratio write lands in the addressed field only
            a_r3_div_write: assert property (@(posedge clk) disable iff (!rst_n)
                (we && addr == DIV_BASE[gi] + ADDR_W'(4 * go))
                |=> (div_o[gi][go] == $past(wdata[DIV_W-1:0])));
        end
    end
endmodule

// File: rtl/clkmux3_chan.sv
module clkmux3_chan
    import clkmux3_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  sel_t                         sel,
    input  logic [NUM_IN-1:0][DIV_W-1:0] ratio,
    input  logic [NUM_IN-1:0]            ref_en,
    output logic                         tick,
    output logic                         run
);
    chan_state_t st_d, st_q;
    logic        en_sel;
    ratio_t      ratio_sel;

    always_comb begin
        case (sel)
            2'd0:    begin en_sel = ref_en[0]; ratio_sel = ratio[0]; end
            2'd1:    begin en_sel = ref_en[1]; ratio_sel = ratio[1]; end
            2'd2:    begin en_sel = ref_en[2]; ratio_sel = ratio[2]; end
            default: begin en_sel = 1'b0;      ratio_sel = '0;       end
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (sel != st_q.sel) begin
            st_d.sel  = sel;
            st_d.cnt  = '0;
            st_d.seen = '0;
        end else if (sel != SEL_OFF && en_sel) begin
            if (st_q.cnt >= ratio_sel) begin
                st_d.cnt  = '0;
                st_d.tick = 1'b1;
                if (st_q.seen != 2'(SEEN_MAX)) begin
                    st_d.seen = st_q.seen + 2'd1;
                end
            end else begin
                st_d.cnt = st_q.cnt + ratio_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sel  <= SEL_OFF;
            st_q.cnt  <= '0;
            st_q.seen <= '0;
            st_q.tick <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = st_q.tick;
    assign run  = (st_q.seen == 2'(SEEN_MAX)) && (sel == st_q.sel) && (sel != SEL_OFF);

    // R6: an off output produces no tick in the following cycle
    a_r6_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_OFF) |=> !tick);

    // R5: a tick only follows an enable pulse of the selected input
    a_r5_tick_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(en_sel));

    // R8: the running flag rises only together with a completed output period
    a_r8_run_after_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> tick);
endmodule

// File: rtl/clkmux3_slice.sv
module clkmux3_slice
    import clkmux3_pkg::*;
#(
    parameter int                NUM_OUT     = 4,
    parameter int                ADDR_W      = 12,
    parameter int                SEL_LSB     = 28,
    parameter int                STAT_LSB    = 4,
    parameter logic [ADDR_W-1:0] SEL_LO_ADDR = 12'h010,
    parameter logic [ADDR_W-1:0] SEL_HI_ADDR = 12'h014,
    parameter logic [ADDR_W-1:0] STAT_BASE   = 12'h020,
    parameter logic [ADDR_W-1:0] DIV_BASE0   = 12'h100,
    parameter logic [ADDR_W-1:0] DIV_BASE1   = 12'h200,
    parameter logic [ADDR_W-1:0] DIV_BASE2   = 12'h300
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         ref_en,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_OUT-1:0] out_tick
);
    logic [NUM_OUT-1:0]                        run;
    logic [NUM_OUT-1:0][SEL_W-1:0]             sel;
    logic [NUM_IN-1:0][NUM_OUT-1:0][DIV_W-1:0] div;

    clkmux3_regs #(
        .NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W), .SEL_LSB(SEL_LSB), .STAT_LSB(STAT_LSB),
        .SEL_LO_ADDR(SEL_LO_ADDR), .SEL_HI_ADDR(SEL_HI_ADDR), .STAT_BASE(STAT_BASE),
        .DIV_BASE0(DIV_BASE0), .DIV_BASE1(DIV_BASE1), .DIV_BASE2(DIV_BASE2)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .run   (run),
        .sel_o (sel),
        .div_o (div)
    );

    for (genvar go = 0; go < NUM_OUT; go++) begin : g_chan
        logic [NUM_IN-1:0][DIV_W-1:0] ratio_o;
        for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_ratio
            assign ratio_o[gi] = div[gi][go];
        end
        clkmux3_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel    (sel[go]),
            .ratio  (ratio_o),
            .ref_en (ref_en),
            .tick   (out_tick[go]),
            .run    (run[go])
        );
    end
endmodule

// File: tb/test_clkmux3_slice.sv
`timescale 1ns/1ps
module test_clkmux3_slice;
    localparam int          NOUT   = 4;
    localparam int          SLSB   = 28;
    localparam int          STLSB  = 4;
    localparam logic [11:0] A_SLO  = 12'h010;
    localparam logic [11:0] A_SHI  = 12'h014;
    localparam logic [11:0] A_STAT = 12'h020;
    localparam logic [11:0] A_DIV [3] = '{12'h100, 12'h200, 12'h300};

    // output, input, ratio, expected tick period in clk cycles
    localparam int NVEC = 8;
    localparam int VEC [NVEC][4] = '{
        '{0, 0, 0, 1},  '{0, 0, 4, 5},  '{1, 1, 2, 6},  '{2, 2, 1, 6},
        '{3, 0, 31, 32}, '{3, 2, 7, 24}, '{1, 1, 0, 2}, '{2, 0, 9, 10}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2:0]      ref_en = 3'b000;
    logic            bus_we = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NOUT-1:0] out_tick;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [31:0] sh_lo = 32'hF000_0000;
    logic [31:0] sh_hi = 32'h0000_000F;

    always #2.5 clk = ~clk;

    clkmux3_slice i_clkmux3_slice (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .out_tick(out_tick)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        ref_en <= {(cyc % 3) == 0, (cyc % 2) == 0, 1'b1};
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_sel(int o, int v);
        int pos;
        pos = SLSB + 2 * o;
        if (pos < 32) begin
            sh_lo[pos +: 2] = 2'(v);
            wr(A_SLO, sh_lo);
        end else begin
            sh_hi[(pos - 32) +: 2] = 2'(v);
            wr(A_SHI, sh_hi);
        end
    endtask

    task automatic stat_bit(int i, int o, output logic b);
        logic [31:0] d;
        rd(A_STAT + 12'(4 * i), d);
        b = d[STLSB + o];
    endtask

    task automatic poll_run(int i, int o, output logic ok);
        logic b;
        ok = 1'b0;
        for (int k = 0; k < 1000 && !ok; k++) begin
            stat_bit(i, o, b);
            ok = b;
        end
    endtask

    task automatic measure(int o, output int per);
        int t;
        t = 0;
        repeat (2) begin
            @(negedge clk);
            while (!out_tick[o] && t < 5000) begin @(negedge clk); t++; end
        end
        per = 0;
        do begin @(negedge clk); per++; end while (!out_tick[o] && per < 5000);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        b;
        int          per;
        int          cnt;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_SLO, d);  check("R1 R2 low select reset", d, 32'hF000_0000);
        rd(A_SHI, d);  check("R1 R2 high select reset", d, 32'h0000_000F);
        rd(A_DIV[1] + 12'h008, d); check("R1 divider reset", d, 32'h0);
        for (int i = 0; i < 3; i++) begin
            rd(A_STAT + 12'(4 * i), d); check("R1 status reset", d, 32'h0);
        end
        cnt = 0;
        repeat (50) begin @(negedge clk); if (out_tick != '0) cnt++; end
        check("R1 no ticks after reset", 32'(cnt), 32'h0);

        // R3 field width and address
        wr(A_DIV[2] + 12'h00C, 32'hFFFF_FFFF);
        rd(A_DIV[2] + 12'h00C, d); check("R3 divider field width", d, 32'h1F);
        rd(A_DIV[2] + 12'h008, d); check("R3 neighbour divider untouched", d, 32'h0);

        // R2 spill into high select register
        wr(A_SHI, 32'hFFFF_FFFE);
        rd(A_SHI, d); check("R2 high select readback", d, 32'h0000_000E);
        rd(A_SLO, d); check("R2 low select untouched", d, 32'hF000_0000);
        wr(A_SHI, 32'h0000_000F);

        // R4 R5 R7 R8 table
        for (int v = 0; v < NVEC; v++) begin
            int o;
            int in;
            o  = VEC[v][0];
            in = VEC[v][1];
            wr(A_DIV[in] + 12'(4 * o), 32'(VEC[v][2]));
            set_sel(o, in);
            poll_run(in, o, b);
            check("R8 running bit asserts", 32'(b), 32'h1);
            for (int i = 0; i < 3; i++) begin
                if (i != in) begin
                    stat_bit(i, o, b);
                    check("R7 other status bit clear", 32'(b), 32'h0);
                end
            end
            measure(o, per);
            check("R4 R5 tick period", 32'(per), 32'(VEC[v][3]));
        end

        // R8 not early, then clear on switch
        wr(A_DIV[2] + 12'h004, 32'd31);
        set_sel(1, 2);
        repeat (10) @(negedge clk);
        stat_bit(2, 1, b); check("R8 running not yet", 32'(b), 32'h0);
        poll_run(2, 1, b); check("R8 running after two periods", 32'(b), 32'h1);
        set_sel(1, 0);
        stat_bit(2, 1, b); check("R8 running drops on switch", 32'(b), 32'h0);

        // R9 unselected divider has no effect
        wr(A_DIV[0], 32'd3);
        set_sel(0, 0);
        measure(0, per); check("R9 period before foreign write", 32'(per), 32'd4);
        wr(A_DIV[1], 32'd9);
        measure(0, per); check("R9 period after foreign write", 32'(per), 32'd4);
        set_sel(0, 1);
        measure(0, per); check("R9 R5 period on new input", 32'(per), 32'd20);

        // R6 off code
        poll_run(1, 0, b); check("R6 running before off", 32'(b), 32'h1);
        set_sel(0, 3);
        @(negedge clk);
        cnt = 0;
        repeat (200) begin @(negedge clk); if (out_tick[0]) cnt++; end
        check("R6 no ticks while off", 32'(cnt), 32'h0);
        for (int i = 0; i < 3; i++) begin
            stat_bit(i, 0, b); check("R6 status clear while off", 32'(b), 32'h0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule